// File: doc/BRIEF.md
# Multi-Line Reservation Monitor

This block keeps the reservation state for a load-reserved / store-conditional sequence that may span up to four cache lines. Each reserved load presents a line address, and the block records it in a small table. A coherence port reports snoop invalidations against the held lines. When software issues the conditional store, the block answers with a one-cycle status pulse carrying pass or fail. A failure is only a value for software to test before it repeats the sequence. It never redirects control.

A consecutive-failure counter provides forward progress. After three failed attempts in a row, the next conditional store runs in ordered mode. The recorded lines are sorted by physical address in a single cycle. They are then locked one at a time in ascending order, and each lock waits for its grant before the next is requested. Because every agent takes its locks in the same global order, two agents cannot deadlock against each other. Snoops that hit lines already locked are held off until the commit. This assumes the attached cache is at least 4-way associative, so that all four lines can stay resident together.

The controller has three named states. OPEN collects reservations and handles unordered commits. SORT captures the sorted line list. LOCK issues the lock requests. The transitions are as follows:
- OPEN→SORT on a conditional store in ordered mode.
- SORT→OPEN when nothing is reserved (commit-empty).
- SORT→LOCK otherwise.
- LOCK→LOCK on each grant that is not the last one.
- LOCK→OPEN on the last grant (commit-locked).
- OPEN→OPEN on an unordered commit or on a reservation.

Top module: `resv_monitor`

## Requirements
- R1: A reserved load (`rsv_valid`) records its line in a free slot. Up to four distinct lines are held. A load to a line that is already held reuses that slot and takes no new one.
- R2: A reserved load to a fifth distinct line raises `ovf_exc` for one cycle, on the cycle after the load. The line is not recorded, a later snoop to it causes no failure, and `fail_cnt` does not change.
- R3: In unordered mode, a snoop (`snp_valid`) whose line matches a held reservation makes the next commit report fail. A snoop to a line that is not held has no effect.
- R4: In unordered mode, `sc_valid` produces `sc_done`=1 in the following cycle. In that cycle `sc_pass`=1 means success and `sc_pass`=0 means failure. The block is then open for a new sequence at once.
- R5: In the cycle in which `sc_done` is high, all reservations and locks have already been released. A snoop to a line from the finished sequence does not fail the next sequence.
- R6: `fail_cnt` is a 3-bit count of consecutive failed commits. It rises by one on each failure, saturates at 7, and clears to 0 on any successful commit.
- R7: `ordered` is 1 while `fail_cnt` >= 3. A commit in ordered mode spends one cycle in SORT. It then raises `lock_req` with the held lines presented on `lock_line` in strictly ascending order. Only one request is outstanding at a time, and each stays presented until `lock_grant`.
- R8: A commit in ordered mode always passes. `sc_done` rises in the cycle after the last grant. If no line is held, it rises in the cycle after SORT.
- R9: During LOCK, a snoop whose line matches an already-granted line drives `snp_hold`=1 combinationally. A snoop to a line that is not yet granted gives `snp_hold`=0. Snoops in ordered mode never cause a failure.
- R10: While `busy`=1 (SORT or LOCK), `rsv_valid` and `sc_valid` are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rsv_valid | input | 1 | Reserved load presented |
| rsv_line | input | LINE_W | Line address of the reserved load |
| sc_valid | input | 1 | Conditional store (commit) request |
| snp_valid | input | 1 | Snoop invalidation presented |
| snp_line | input | LINE_W | Line address of the snoop |
| lock_grant | input | 1 | Cache grants the current lock request |
| sc_done | output | 1 | Commit status valid (one cycle) |
| sc_pass | output | 1 | Commit status: 1 pass, 0 fail |
| ovf_exc | output | 1 | Hard exception: more than four lines reserved |
| lock_req | output | 1 | Lock request outstanding |
| lock_line | output | LINE_W | Line to lock |
| snp_hold | output | 1 | Stall the presented snoop |
| busy | output | 1 | Ordered commit in progress |
| ordered | output | 1 | Next commit runs in ordered mode |
| fail_cnt | output | 3 | Consecutive failure count |

## Verification
The checker watches several properties on every cycle:
- the table is empty whenever a status is shown;
- a pass leaves the counter at zero, and a fail raises it by one;
- an overflow leaves the counter untouched;
- lock requests appear only in ordered mode, and successive requested lines strictly ascend;
- a snoop hold appears only while a lock is outstanding.

The bench scenarios are needed for the rest:
- duplicate reuse of a slot, seen through which load overflows;
- the pass or fail verdict after particular snoop patterns;
- the exact latency of status and locks;
- the absence of effect from stimulus given while busy;
- the full sorted lock order against a scoreboard.

// File: rtl/resv_mon_pkg.sv
package resv_mon_pkg;
    // Number of line reservations; the sorting network is built for exactly four.
    localparam int RM_SLOTS = 4;

    typedef enum logic [1:0] {
        ST_OPEN = 2'd0,
        ST_SORT = 2'd1,
        ST_LOCK = 2'd2
    } mon_state_e;
endpackage

// File: rtl/resv_slot_table.sv
module resv_slot_table
    import resv_mon_pkg::*;
#(
    parameter int LINE_W = 26,
    parameter int SLOTS  = RM_SLOTS,
    localparam int CNT_W = $clog2(SLOTS + 1),
    localparam int IDX_W = $clog2(SLOTS)
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           clr,
    input  logic                           wr_en,
    input  logic [LINE_W-1:0]              wr_line,
    input  logic [LINE_W-1:0]              snp_line,
    output logic [SLOTS-1:0]               slot_vld,
    output logic [SLOTS-1:0][LINE_W-1:0]   slot_line,
    output logic                           wr_ovf,
    output logic                           snp_hit,
    output logic [CNT_W-1:0]               slot_cnt
);
    logic [SLOTS-1:0] wr_match;
    logic [SLOTS-1:0] snp_match;
    logic             wr_hit;
    logic             full;
    logic [IDX_W-1:0] free_idx;

    // One address comparator pair per slot.
    for (genvar g = 0; g < SLOTS; g++) begin : g_cmp
        assign wr_match[g]  = slot_vld[g] && (slot_line[g] == wr_line);
        assign snp_match[g] = slot_vld[g] && (slot_line[g] == snp_line);
    end

    assign wr_hit  = |wr_match;
    assign snp_hit = |snp_match;
    assign full    = &slot_vld;
    assign wr_ovf  = wr_en && !wr_hit && full;

    always_comb begin
        logic found;
        found    = 1'b0;
        free_idx = '0;
        for (int i = 0; i < SLOTS; i++) begin
            if (!slot_vld[i] && !found) begin
                free_idx = IDX_W'(i);
                found    = 1'b1;
            end
        end
    end

    always_comb begin
        slot_cnt = '0;
        for (int i = 0; i < SLOTS; i++) begin
            slot_cnt = slot_cnt + CNT_W'(slot_vld[i]);
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            slot_vld  <= '0;
            slot_line <= '0;
        end else if (clr) begin
            slot_vld  <= '0;
        end else if (wr_en && !wr_hit && !full) begin
            slot_vld[free_idx]  <= 1'b1;
            slot_line[free_idx] <= wr_line;
        end
    end
endmodule

// File: rtl/resv_sort4.sv
module resv_sort4 #(
    parameter int LINE_W = 26,
    localparam int KEY_W = LINE_W + 1
) (
    input  logic [3:0]              in_vld,
    input  logic [3:0][LINE_W-1:0]  in_line,
    output logic [3:0]              out_vld,
    output logic [3:0][LINE_W-1:0]  out_line
);
    // Key puts empty slots last: {empty, address}.
    logic [3:0][KEY_W-1:0] s0, s1, s2, s3;

    function automatic logic [KEY_W-1:0] kmin(input logic [KEY_W-1:0] a, input logic [KEY_W-1:0] b);
        return (a < b) ? a : b;
    endfunction

    function automatic logic [KEY_W-1:0] kmax(input logic [KEY_W-1:0] a, input logic [KEY_W-1:0] b);
        return (a < b) ? b : a;
    endfunction

    for (genvar g = 0; g < 4; g++) begin : g_key
        assign s0[g] = {~in_vld[g], in_line[g]};
    end

    // Five compare-exchange units in three layers.
    always_comb begin
        s1[0] = kmin(s0[0], s0[1]);  s1[1] = kmax(s0[0], s0[1]);
        s1[2] = kmin(s0[2], s0[3]);  s1[3] = kmax(s0[2], s0[3]);
        s2[0] = kmin(s1[0], s1[2]);  s2[2] = kmax(s1[0], s1[2]);
        s2[1] = kmin(s1[1], s1[3]);  s2[3] = kmax(s1[1], s1[3]);
        s3[0] = s2[0];
        s3[1] = kmin(s2[1], s2[2]);  s3[2] = kmax(s2[1], s2[2]);
        s3[3] = s2[3];
    end

    for (genvar g = 0; g < 4; g++) begin : g_out
        assign out_vld[g]  = ~s3[g][KEY_W-1];
        assign out_line[g] = s3[g][LINE_W-1:0];
    end
endmodule

// File: rtl/resv_retry_ctr.sv
module resv_retry_ctr #(
    parameter int FAIL_W     = 3,
    parameter int ESC_THRESH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              inc,
    input  logic              clr,
    output logic [FAIL_W-1:0] cnt,
    output logic              escalate
);
    localparam logic [FAIL_W-1:0] CNT_MAX = '1;
    localparam logic [FAIL_W-1:0] THR     = FAIL_W'(ESC_THRESH);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt <= '0;
        end else if (clr) begin
            cnt <= '0;
        end else if (inc && cnt != CNT_MAX) begin
            cnt <= cnt + 1'b1;
        end
    end

    assign escalate = (cnt >= THR);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor
    import resv_mon_pkg::*;
#(
    parameter int LINE_W     = 26,
    parameter int FAIL_W     = 3,
    parameter int ESC_THRESH = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rsv_valid,
    input  logic [LINE_W-1:0] rsv_line,
    input  logic              sc_valid,
    input  logic              snp_valid,
    input  logic [LINE_W-1:0] snp_line,
    input  logic              lock_grant,
    output logic              sc_done,
    output logic              sc_pass,
    output logic              ovf_exc,
    output logic              lock_req,
    output logic [LINE_W-1:0] lock_line,
    output logic              snp_hold,
    output logic              busy,
    output logic              ordered,
    output logic [FAIL_W-1:0] fail_cnt
);
    localparam int SLOTS = RM_SLOTS;
    localparam int CNT_W = $clog2(SLOTS + 1);
    localparam int IDX_W = $clog2(SLOTS);

    mon_state_e state_q, state_d;

    logic [SLOTS-1:0]             slot_vld;
    logic [SLOTS-1:0][LINE_W-1:0] slot_line;
    logic [SLOTS-1:0]             srt_vld;
    logic [SLOTS-1:0][LINE_W-1:0] srt_line;
    logic [SLOTS-1:0]             srt_vld_q;
    logic [SLOTS-1:0][LINE_W-1:0] srt_q;
    logic [CNT_W-1:0]             slot_cnt;
    logic [CNT_W-1:0]             lk_idx_q;
    logic                         wr_ovf, snp_hit, failed_q;

    logic tbl_clr, tbl_wr, commit_ok, commit_bad, latch_sort, idx_adv, fail_mark;

    resv_slot_table #(.LINE_W(LINE_W), .SLOTS(SLOTS)) u_table (
        .clk(clk), .rst_n(rst_n), .clr(tbl_clr), .wr_en(tbl_wr), .wr_line(rsv_line),
        .snp_line(snp_line), .slot_vld(slot_vld), .slot_line(slot_line),
        .wr_ovf(wr_ovf), .snp_hit(snp_hit), .slot_cnt(slot_cnt)
    );

    resv_sort4 #(.LINE_W(LINE_W)) u_sort (
        .in_vld(slot_vld), .in_line(slot_line), .out_vld(srt_vld), .out_line(srt_line)
    );

    resv_retry_ctr #(.FAIL_W(FAIL_W), .ESC_THRESH(ESC_THRESH)) u_retry (
        .clk(clk), .rst_n(rst_n), .inc(commit_bad), .clr(commit_ok),
        .cnt(fail_cnt), .escalate(ordered)
    );

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_OPEN;
        else        state_q <= state_d;
    end

    // Next state and control strobes.
    always_comb begin
        state_d    = state_q;
        tbl_wr     = 1'b0;
        commit_ok  = 1'b0;
        commit_bad = 1'b0;
        latch_sort = 1'b0;
        idx_adv    = 1'b0;
        fail_mark  = 1'b0;
        unique case (state_q)
            ST_OPEN: begin
                fail_mark = snp_valid && snp_hit && !ordered;
                if (sc_valid) begin
                    if (ordered) begin
                        state_d = ST_SORT;
                    end else if (failed_q || fail_mark) begin
                        commit_bad = 1'b1;
                    end else begin
                        commit_ok = 1'b1;
                    end
                end else begin
                    tbl_wr = rsv_valid;
                end
            end
            ST_SORT: begin
                latch_sort = 1'b1;
                if (slot_cnt == '0) begin
                    commit_ok = 1'b1;
                    state_d   = ST_OPEN;
                end else begin
                    state_d = ST_LOCK;
                end
            end
            ST_LOCK: begin
                if (lock_grant) begin
                    if (lk_idx_q + 1'b1 == slot_cnt) begin
                        commit_ok = 1'b1;
                        state_d   = ST_OPEN;
                    end else begin
                        idx_adv = 1'b1;
                    end
                end
            end
            default: state_d = ST_OPEN;
        endcase
    end

    assign tbl_clr = commit_ok || commit_bad;

    // Registered outputs and datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sc_done   <= 1'b0;
            sc_pass   <= 1'b0;
            ovf_exc   <= 1'b0;
            failed_q  <= 1'b0;
            lk_idx_q  <= '0;
            srt_q     <= '0;
            srt_vld_q <= '0;
        end else begin
            sc_done <= commit_ok || commit_bad;
            sc_pass <= commit_ok;
            ovf_exc <= tbl_wr && wr_ovf;
            if (tbl_clr)        failed_q <= 1'b0;
            else if (fail_mark) failed_q <= 1'b1;
            if (latch_sort) begin
                srt_q     <= srt_line;
                srt_vld_q <= srt_vld;
                lk_idx_q  <= '0;
            end else if (idx_adv) begin
                lk_idx_q  <= lk_idx_q + 1'b1;
            end
        end
    end

    assign busy      = (state_q != ST_OPEN);
    assign lock_req  = (state_q == ST_LOCK);
    assign lock_line = srt_q[lk_idx_q[IDX_W-1:0]];

    // Hold snoops that hit a line whose lock was already granted.
    always_comb begin
        snp_hold = 1'b0;
        if (lock_req && snp_valid) begin
            for (int i = 0; i < SLOTS; i++) begin
                if (CNT_W'(i) < lk_idx_q && srt_vld_q[i] && srt_q[i] == snp_line)
                    snp_hold = 1'b1;
            end
        end
    end
endmodule

// File: rtl/resv_monitor_chk.sv
module resv_monitor_chk #(
    parameter int LINE_W = 26,
    parameter int FAIL_W = 3,
    parameter int CNT_W  = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sc_done,
    input logic              sc_pass,
    input logic              ovf_exc,
    input logic              lock_req,
    input logic              lock_grant,
    input logic [LINE_W-1:0] lock_line,
    input logic              ordered,
    input logic              snp_hold,
    input logic [FAIL_W-1:0] fail_cnt,
    input logic [CNT_W-1:0]  slot_cnt
);
    assert_release_on_status_R5: assert property (@(posedge clk) disable iff (!rst_n)
        sc_done |-> slot_cnt == '0);

    assert_pass_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && sc_pass) |-> fail_cnt == '0);

    assert_fail_counts_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (sc_done && !sc_pass) |->
            (fail_cnt == $past(fail_cnt) + 1'b1) || ($past(fail_cnt) == '1));

    assert_ovf_not_failure_R2: assert property (@(posedge clk) disable iff (!rst_n)
        ovf_exc |-> (fail_cnt == $past(fail_cnt)) && !sc_done);

    assert_lock_only_ordered_R7: assert property (@(posedge clk) disable iff (!rst_n)
        lock_req |-> ordered);

    assert_lock_ascending_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(lock_req && lock_grant) && lock_req) |-> lock_line > $past(lock_line));

    assert_hold_needs_lock_R9: assert property (@(posedge clk) disable iff (!rst_n)
        snp_hold |-> lock_req);
endmodule

bind resv_monitor resv_monitor_chk #(.LINE_W(LINE_W), .FAIL_W(FAIL_W), .CNT_W(CNT_W)) chk_i (
    .clk(clk), .rst_n(rst_n), .sc_done(sc_done), .sc_pass(sc_pass), .ovf_exc(ovf_exc),
    .lock_req(lock_req), .lock_grant(lock_grant), .lock_line(lock_line), .ordered(ordered),
    .snp_hold(snp_hold), .fail_cnt(fail_cnt), .slot_cnt(slot_cnt)
);

// File: tb/resv_monitor_tb_top.sv
module resv_monitor_tb_top;
    localparam int LW = 26;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rsv_valid = 1'b0, sc_valid = 1'b0, snp_valid = 1'b0, lock_grant = 1'b0;
    logic [LW-1:0] rsv_line = '0, snp_line = '0;
    logic          sc_done, sc_pass, ovf_exc, lock_req, snp_hold, busy, ordered;
    logic [LW-1:0] lock_line;
    logic [2:0]    fail_cnt;

    int total = 0;
    int bad   = 0;
    int gnt_delay = 0;
    int wait_c = 0;

    bit            exp_st[$];
    logic [LW-1:0] exp_lk[$];

    always #4 clk = ~clk;

    resv_monitor #(.LINE_W(LW)) dut_i (
        .clk(clk), .rst_n(rst_n), .rsv_valid(rsv_valid), .rsv_line(rsv_line),
        .sc_valid(sc_valid), .snp_valid(snp_valid), .snp_line(snp_line),
        .lock_grant(lock_grant), .sc_done(sc_done), .sc_pass(sc_pass), .ovf_exc(ovf_exc),
        .lock_req(lock_req), .lock_line(lock_line), .snp_hold(snp_hold), .busy(busy),
        .ordered(ordered), .fail_cnt(fail_cnt)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: status scoreboard.
    always @(negedge clk) begin
        if (rst_n && sc_done) begin
            if (exp_st.size() == 0) begin
                check(1'b0, "R4 unexpected status", 1, 0);
            end else begin
                bit e;
                e = exp_st.pop_front();
                check(sc_pass == e, "R4/R8 status value", sc_pass, e);
            end
        end
    end

    // Grant responder and lock scoreboard.
    always @(negedge clk) begin
        if (lock_grant) begin
            lock_grant = 1'b0;
            wait_c = 0;
        end else if (lock_req) begin
            if (wait_c >= gnt_delay) begin
                if (exp_lk.size() == 0) begin
                    check(1'b0, "R7 unexpected lock", lock_line, 0);
                end else begin
                    logic [LW-1:0] e;
                    e = exp_lk.pop_front();
                    check(lock_line == e, "R7 lock order", lock_line, e);
                end
                lock_grant = 1'b1;
            end else begin
                wait_c++;
            end
        end
    end

    task automatic reserve(input logic [LW-1:0] line, output bit ovf);
        rsv_valid = 1'b1; rsv_line = line;
        @(negedge clk);
        ovf = ovf_exc;
        rsv_valid = 1'b0;
    endtask

    task automatic snoop(input logic [LW-1:0] line);
        snp_valid = 1'b1; snp_line = line;
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic commit(input bit exp_pass);
        exp_st.push_back(exp_pass);
        sc_valid = 1'b1;
        @(negedge clk);
        sc_valid = 1'b0;
    endtask

    task automatic wait_idle();
        while (busy) @(negedge clk);
    endtask

    task automatic fail_once(input logic [LW-1:0] line, input logic [2:0] exp_cnt);
        bit o;
        reserve(line, o);
        snoop(line);
        commit(1'b0);
        check(sc_done == 1'b1 && sc_pass == 1'b0, "R3 snoop hit fails", sc_pass, 0);
        check(fail_cnt == exp_cnt, "R6 count up", fail_cnt, exp_cnt);
    endtask

    initial begin
        #(8 * 100000);
        check(1'b0, "watchdog", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        bit o;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(!sc_done && !ovf_exc && !lock_req && !busy && fail_cnt == 0 && !ordered,
              "reset state", {sc_done, ovf_exc, lock_req, busy, fail_cnt}, 0);

        // R1 / R2: duplicate reuses a slot, fifth distinct line overflows.
        reserve(26'h100, o); check(!o, "R1 first line", o, 0);
        reserve(26'h200, o);
        reserve(26'h100, o); check(!o, "R1 duplicate", o, 0);
        reserve(26'h300, o);
        reserve(26'h400, o); check(!o, "R1 fourth distinct no overflow", o, 0);
        reserve(26'h500, o); check(o, "R2 fifth distinct overflows", o, 1);
        check(fail_cnt == 0, "R2 overflow not counted", fail_cnt, 0);
        @(negedge clk);
        check(!ovf_exc, "R2 exception is a pulse", ovf_exc, 0);
        snoop(26'h500);   // R2: unrecorded line
        snoop(26'h777);   // R3: unrelated line
        commit(1'b1);
        check(sc_done && sc_pass, "R4 pass next cycle", {sc_done, sc_pass}, 3);
        @(negedge clk);
        check(!sc_done, "R4 status one cycle", sc_done, 0);

        // R5: old line snooped after release does not fail new sequence.
        snoop(26'h100);
        reserve(26'h200, o);
        commit(1'b1);
        check(sc_pass && fail_cnt == 0, "R5 released lines", sc_pass, 1);

        // R6: three failures escalate.
        fail_once(26'h010, 3'd1);
        check(!ordered, "R7 not ordered at 1", ordered, 0);
        fail_once(26'h020, 3'd2);
        fail_once(26'h030, 3'd3);
        check(ordered, "R7 ordered at 3", ordered, 1);

        // R7 / R8 / R9 / R10: ordered commit with four lines.
        reserve(26'h40, o);
        reserve(26'h10, o);
        reserve(26'h30, o);
        reserve(26'h20, o);
        snoop(26'h10);    // R9: no failure in ordered mode
        gnt_delay = 3;
        exp_lk.push_back(26'h10); exp_lk.push_back(26'h20);
        exp_lk.push_back(26'h30); exp_lk.push_back(26'h40);
        commit(1'b1);
        check(busy && !sc_done, "R7 sort cycle", busy, 1);
        reserve(26'h50, o);   // R10: ignored while busy, table full
        @(negedge clk);
        check(!ovf_exc, "R10 load ignored while busy", ovf_exc, 0);
        while (!(lock_req && lock_line == 26'h20)) @(negedge clk);
        snp_valid = 1'b1; snp_line = 26'h10;
        #1 check(snp_hold, "R9 hold on granted line", snp_hold, 1);
        snp_line = 26'h30;
        #1 check(!snp_hold, "R9 no hold on ungranted line", snp_hold, 0);
        snp_valid = 1'b0;
        wait_idle();
        check(sc_done && sc_pass, "R8 ordered pass", {sc_done, sc_pass}, 3);
        check(fail_cnt == 0 && !ordered, "R6 pass clears count", fail_cnt, 0);
        check(exp_lk.size() == 0, "R7 all lines locked", exp_lk.size(), 0);

        // R8: ordered commit with nothing reserved.
        fail_once(26'h011, 3'd1);
        fail_once(26'h012, 3'd2);
        fail_once(26'h013, 3'd3);
        commit(1'b1);
        check(busy && !sc_done, "R8 empty sort cycle", sc_done, 0);
        @(negedge clk);
        check(sc_done && sc_pass && !busy, "R8 empty commit after sort", {sc_done, sc_pass}, 3);

        repeat (3) @(negedge clk);
        check(exp_st.size() == 0, "R4 all statuses seen", exp_st.size(), 0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule